// File: doc/BRIEF.md
# Configurable Product-Term AND Plane

This block is the sum-of-products front end of a small programmable logic block. A 36-bit input vector is expanded into 72 literal lines, the true and the inverted copy of every input. Each of 83 product terms is the AND of whichever literal lines its configuration mask selects. The first 80 terms are logic terms. They are grouped in order into 16 clusters of five, one cluster per macrocell. The last three terms are shared control terms: a clock, an initialization and an output enable. The clock and initialization terms each carry a polarity bit.

The configuration is held in registers and loaded through a parallel write port, one product term per clock cycle. Each write carries a 72-bit literal mask, a force-off bit and a polarity bit. Every output is a combinational function of the input vector and the stored configuration. The macrocell registers, the routing and the I/O cells downstream consume these outputs and are not part of this block.

Top module: `pt_and_plane`

## Requirements
- R1: Literal line 2*i is input bit i and line 2*i+1 is its complement. A product term is the AND of the lines whose bits are set in its 72-bit mask, where mask bit j selects line j.
- R2: A term whose mask is all zero and whose force-off bit is clear evaluates to 1.
- R3: A term whose force-off bit is set evaluates to 0, whatever its mask and the inputs.
- R4: A term that selects both the true and the complement line of the same input evaluates to 0.
- R5: Logic term k (0 to 79) appears on bit k of `logic_pt`. Cluster c is made of bits 5c to 5c+4.
- R6: `shr_clk` equals term 80 XOR the polarity bit written with index 80. `shr_init` equals term 81 XOR the polarity bit written with index 81.
- R7: `shr_oe` equals term 82. The polarity bit written with index 82 has no effect.
- R8: When `cfg_we` is high at a rising clock edge and `cfg_idx` is 0 to 82, that term's mask, force-off bit and (for 80 and 81) polarity bit are replaced. The new configuration drives the outputs from that edge on.
- R9: A write whose index is 83 to 127 changes no stored configuration and no output.
- R10: While reset is held, and after it is released until the first write, every mask is clear, every force-off bit is set and both polarity bits are clear. All outputs are therefore 0.
- R11: The outputs follow a change on `pins_in` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low synchronous reset of the configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 7 | Index of the product term to write |
| cfg_mask | input | 72 | Literal-line select mask for that term |
| cfg_off | input | 1 | Force-off bit for that term |
| cfg_inv | input | 1 | Polarity bit (used for indices 80 and 81 only) |
| pins_in | input | 36 | Input vector |
| logic_pt | output | 80 | Logic product terms, five per cluster |
| shr_clk | output | 1 | Shared clock term after polarity |
| shr_init | output | 1 | Shared initialization term after polarity |
| shr_oe | output | 1 | Shared output-enable term |

## Verification
The bench first probes the literal ordering with single-literal masks. A design that swaps the true and complement lines would flip those terms. It then drives empty, forced-off and contradictory masks. A wrong empty-term default shows up as 0 where 1 is expected, and a force-off that is ignored lets a term pass. It writes to every out-of-range index. A design that wraps the index would overwrite a low term, which changes the whole-vector comparison. It toggles the polarity bit on all three shared terms, so polarity applied to the output enable, or to the wrong term, is caught. It also runs randomized sparse masks across the full term range, with inputs chosen to satisfy a chosen term. An off-by-one in the cluster or term numbering would then misplace bits.

// File: rtl/pt_pkg.sv
package pt_pkg;
    // Role of each shared control term, in its order after the logic terms.
    typedef enum logic [1:0] {
        SHR_CLK  = 2'd0,
        SHR_INIT = 2'd1,
        SHR_OE   = 2'd2
    } shr_role_e;

    localparam int N_SHR = 3;

    // Index of a shared term given the count of logic terms.
    function automatic int shr_index(input int n_logic, input shr_role_e role);
        return n_logic + int'(role);
    endfunction
endpackage

// File: rtl/pt_literals.sv
module pt_literals #(
    parameter int N_IN = 36,
    localparam int N_LINES = 2 * N_IN
) (
    input  logic [N_IN-1:0]    pins_in,
    output logic [N_LINES-1:0] lines
);
    // Even line: true literal, odd line: complement.
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lines[2*i]   = pins_in[i];
        assign lines[2*i+1] = ~pins_in[i];
    end
endmodule

// File: rtl/pt_cfg_store.sv
module pt_cfg_store #(
    parameter int N_LINES = 72,
    parameter int N_PT    = 83,
    parameter int N_LOGIC = 80,
    parameter int IDX_W   = 7
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [IDX_W-1:0]               cfg_idx,
    input  logic [N_LINES-1:0]             cfg_mask,
    input  logic                           cfg_off,
    input  logic                           cfg_inv,
    output logic [N_PT-1:0][N_LINES-1:0]   mask_q,
    output logic [N_PT-1:0]                off_q,
    output logic [1:0]                     inv_q
);
    logic idx_ok;
    assign idx_ok = (int'(cfg_idx) < N_PT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            off_q  <= '1;
            inv_q  <= '0;
        end else if (cfg_we && idx_ok) begin
            mask_q[cfg_idx] <= cfg_mask;
            off_q[cfg_idx]  <= cfg_off;
            if (int'(cfg_idx) == N_LOGIC)     inv_q[0] <= cfg_inv;
            if (int'(cfg_idx) == N_LOGIC + 1) inv_q[1] <= cfg_inv;
        end
    end

    // R9: an out-of-range write leaves all configuration untouched
    p_hi_idx_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !idx_ok) |=> ($stable(mask_q) && $stable(off_q) && $stable(inv_q)));

    // R8: an in-range write lands in the addressed entry
    p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && idx_ok) |=> (mask_q[$past(cfg_idx)] == $past(cfg_mask)
                                && off_q[$past(cfg_idx)] == $past(cfg_off)));
endmodule

// File: rtl/pt_term.sv
module pt_term #(
    parameter int N_LINES = 72
) (
    input  logic [N_LINES-1:0] lines,
    input  logic [N_LINES-1:0] mask,
    input  logic               off,
    output logic               pt
);
    // Unselected lines read as 1, so an empty mask gives a true term.
    always_comb begin
        pt = ~off & (&(lines | ~mask));
    end
endmodule

// File: rtl/pt_and_plane.sv
module pt_and_plane #(
    parameter int N_IN       = 36,
    parameter int N_CLUSTER  = 16,
    parameter int CLUSTER_SZ = 5,
    localparam int N_LINES   = 2 * N_IN,
    localparam int N_LOGIC   = N_CLUSTER * CLUSTER_SZ,
    localparam int N_PT      = N_LOGIC + pt_pkg::N_SHR,
    localparam int IDX_W     = $clog2(N_PT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [N_LINES-1:0] cfg_mask,
    input  logic               cfg_off,
    input  logic               cfg_inv,
    input  logic [N_IN-1:0]    pins_in,
    output logic [N_LOGIC-1:0] logic_pt,
    output logic               shr_clk,
    output logic               shr_init,
    output logic               shr_oe
);
    import pt_pkg::*;

    localparam int I_CLK  = shr_index(N_LOGIC, SHR_CLK);
    localparam int I_INIT = shr_index(N_LOGIC, SHR_INIT);
    localparam int I_OE   = shr_index(N_LOGIC, SHR_OE);

    logic [N_LINES-1:0]           lines;
    logic [N_PT-1:0][N_LINES-1:0] mask_q;
    logic [N_PT-1:0]              off_q;
    logic [1:0]                   inv_q;
    logic [N_PT-1:0]              pt_all;

    pt_literals #(.N_IN(N_IN)) u_lit (
        .pins_in (pins_in),
        .lines   (lines)
    );

    pt_cfg_store #(
        .N_LINES (N_LINES),
        .N_PT    (N_PT),
        .N_LOGIC (N_LOGIC),
        .IDX_W   (IDX_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_mask (cfg_mask),
        .cfg_off  (cfg_off),
        .cfg_inv  (cfg_inv),
        .mask_q   (mask_q),
        .off_q    (off_q),
        .inv_q    (inv_q)
    );

    for (genvar k = 0; k < N_PT; k++) begin : g_pt
        pt_term #(.N_LINES(N_LINES)) u_term (
            .lines (lines),
            .mask  (mask_q[k]),
            .off   (off_q[k]),
            .pt    (pt_all[k])
        );
    end

    assign logic_pt = pt_all[N_LOGIC-1:0];
    assign shr_clk  = pt_all[I_CLK]  ^ inv_q[0];
    assign shr_init = pt_all[I_INIT] ^ inv_q[1];
    assign shr_oe   = pt_all[I_OE];

    // R10: configuration comes out of reset with every output low
    p_reset_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (logic_pt == '0 && !shr_clk && !shr_init && !shr_oe));

    // R3: a forced-off logic term stays low
    p_force_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && int'(cfg_idx) < N_LOGIC && cfg_off)
            |=> !logic_pt[$past(cfg_idx)]);

    // R2: an enabled empty logic term reads 1
    p_empty_true_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && int'(cfg_idx) < N_LOGIC && !cfg_off && cfg_mask == '0)
            |=> logic_pt[$past(cfg_idx)]);

    // R4: selecting both literals of input 0 kills the term
    p_contra_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && int'(cfg_idx) < N_LOGIC && cfg_mask[1:0] == 2'b11)
            |=> !logic_pt[$past(cfg_idx)]);

    // R7: output enable ignores the polarity bit
    p_oe_no_inv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && int'(cfg_idx) == I_OE && !cfg_off && cfg_mask == '0)
            |=> shr_oe);
endmodule

// File: tb/pt_and_plane_bench.sv
module pt_and_plane_bench;
    localparam int NI = 36;
    localparam int NL = 72;
    localparam int NG = 80;
    localparam int NP = 83;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [6:0]    cfg_idx = '0;
    logic [NL-1:0] cfg_mask = '0;
    logic          cfg_off = 1'b0;
    logic          cfg_inv = 1'b0;
    logic [NI-1:0] pins_in = '0;
    logic [NG-1:0] logic_pt;
    logic          shr_clk, shr_init, shr_oe;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    logic [NL-1:0] bmask [NP];
    logic          boff  [NP];
    logic [1:0]    binv;

    always #4 clk = ~clk;

    pt_and_plane u_pt_and_plane (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_mask(cfg_mask), .cfg_off(cfg_off), .cfg_inv(cfg_inv),
        .pins_in(pins_in), .logic_pt(logic_pt), .shr_clk(shr_clk),
        .shr_init(shr_init), .shr_oe(shr_oe)
    );

    function automatic logic model_pt(input int k, input logic [NI-1:0] x);
        if (boff[k]) return 1'b0;
        for (int i = 0; i < NI; i++) begin
            if (bmask[k][2*i] && !x[i]) return 1'b0;
            if (bmask[k][2*i+1] && x[i]) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic check_all(input string tag);
        logic [NG-1:0] exp_l;
        logic [2:0] exp_s, act_s;
        for (int k = 0; k < NG; k++) exp_l[k] = model_pt(k, pins_in);
        exp_s = {model_pt(82, pins_in), model_pt(81, pins_in) ^ binv[1],
                 model_pt(80, pins_in) ^ binv[0]};
        act_s = {shr_oe, shr_init, shr_clk};
        compared++;
        if (logic_pt !== exp_l || act_s !== exp_s) begin
            mismatched++;
            $display("FAIL %s: logic_pt=%h shr=%b expected logic_pt=%h shr=%b",
                     tag, logic_pt, act_s, exp_l, exp_s);
        end
    endtask

    task automatic wr(input int idx, input logic [NL-1:0] m, input logic off, input logic inv);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx[6:0]; cfg_mask = m; cfg_off = off; cfg_inv = inv;
        @(negedge clk);
        cfg_we = 1'b0;
        if (idx < NP) begin
            bmask[idx] = m; boff[idx] = off;
            if (idx == 80) binv[0] = inv;
            if (idx == 81) binv[1] = inv;
        end
    endtask

    task automatic set_in(input logic [NI-1:0] v);
        pins_in = v;
        #1;
    endtask

    function automatic logic [NL-1:0] rand_mask();
        logic [NL-1:0] m = '0;
        for (int i = 0; i < NI; i++) begin
            int r = $urandom % 16;
            if (r == 0) m[2*i] = 1'b1;
            else if (r == 1) m[2*i+1] = 1'b1;
            else if (r == 2 && ($urandom % 4) == 0) begin
                m[2*i] = 1'b1; m[2*i+1] = 1'b1;
            end
        end
        return m;
    endfunction

    initial begin
        #1_200_000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NP; k++) begin bmask[k] = '0; boff[k] = 1'b1; end
        binv = 2'b00;
        repeat (3) @(negedge clk);
        set_in('1);
        check_all("R10 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        set_in(36'h5_A5A5_A5A5);
        check_all("R10 after reset");

        // R1: single true literal on input 3 for term 0, complement for term 1
        wr(0, 72'd1 << 6, 1'b0, 1'b0);
        wr(1, 72'd1 << 7, 1'b0, 1'b0);
        set_in(36'h0_0000_0008); check_all("R1 true literal high");
        set_in(36'h0_0000_0000); check_all("R1 true literal low");
        // R2 / R3: empty term and forced-off term
        wr(2, '0, 1'b0, 1'b0);
        wr(3, '1, 1'b1, 1'b0);
        set_in(36'h9_1234_5678); check_all("R2 empty term true, R3 forced off");
        // R4: both literals of input 5
        wr(4, 72'd3 << 10, 1'b0, 1'b0);
        set_in(36'h0_0000_0020); check_all("R4 contradiction in5=1");
        set_in(36'h0_0000_0000); check_all("R4 contradiction in5=0");
        // R6 / R7: shared terms with polarity
        wr(80, '0, 1'b0, 1'b1);
        wr(81, '0, 1'b0, 1'b0);
        wr(82, '0, 1'b0, 1'b1);
        check_all("R6 R7 polarity set on clk and oe");
        wr(80, '0, 1'b0, 1'b0);
        wr(81, 72'd1 << 1, 1'b0, 1'b1);
        set_in(36'h0_0000_0001); check_all("R6 init inverted, in0 high");
        set_in(36'h0_0000_0000); check_all("R6 init inverted, in0 low");
        // R9: out-of-range indices, empty enabled masks with polarity set
        for (int idx = 83; idx < 128; idx++) begin
            wr(idx, '0, 1'b0, 1'b1);
            check_all("R9 out-of-range write");
        end
        // R5 / R8 / R11: random sparse configurations over all terms
        for (int round = 0; round < 8; round++) begin
            for (int k = 0; k < NP; k++)
                wr(k, rand_mask(), ($urandom % 10) == 0, $urandom % 2);
            for (int v = 0; v < 60; v++) begin
                int t = $urandom % NP;
                logic [NI-1:0] x = {$urandom, $urandom};
                for (int i = 0; i < NI; i++) begin
                    if (bmask[t][2*i] && !bmask[t][2*i+1]) x[i] = 1'b1;
                    if (bmask[t][2*i+1] && !bmask[t][2*i]) x[i] = 1'b0;
                end
                // R11: inputs change with no clock edge between checks
                set_in(x);
                check_all("R5 R8 R11 random sweep");
            end
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule